// File: doc/BRIEF.md
# Two-Stage Serial Bit-Clock Prescaler

This block derives the bit clock of a serial controller from the functional input clock. It divides in two stages. The first stage is shared and divides by 2, 4, 7 or 10, chosen by a 2-bit index. The second stage divides by 2, 4 or 8, chosen per transfer by a 2-bit code. The bit-clock period is therefore the product of the two ratios, and the slowest setting gives one bit per 80 input cycles.

A global enable gates the whole clock. While the enable is low, both counters are held at zero and the bit clock rests at its idle level. An inversion input selects whether that idle level is low or high. A start pulse restarts the period, so the first bit of a transfer always gets a full period. The first stage may divide by an odd ratio. The second stage is always even, so the bit clock has exactly equal halves.

The block also produces two single-cycle strobes, one for shifting data out and one for sampling data in. Each strobe lines up with one of the two bit-clock edges. A select input chooses which edge drives which strobe. The ratio, inversion and edge selections are meant to be changed only while the enable is low or in the same cycle as a start pulse.

Top module: `sclk_prescaler`

## Requirements
- R1: The first-stage index `pre_sel_i` selects the divide ratio: 0 gives 2, 1 gives 4, 2 gives 7 and 3 gives 10 input cycles per stage-one tick.
- R2: The second-stage code `post_sel_i` selects the divide ratio: 2'b00 gives 2 ticks, 2'b01 gives 4 and 2'b10 gives 8; code 2'b11 also gives 8.
- R3: The bit-clock period is P = R1 ratio × R2 ratio input cycles. Count cycle k = 0 as the first cycle in which `clk_en_i` is high. Over k mod P in [0, P/2) `sclk_o` sits at the idle level, and over [P/2, P) it sits at the active level.
- R4: While `clk_en_i` is low, from the next cycle on `sclk_o` equals the idle level and both strobes stay low.
- R5: The idle level of `sclk_o` equals `invert_i`, and the active level is its complement.
- R6: A high `start_i` restarts the period. The cycle after it is cycle k = 0 of R3, no matter where the old period stood.
- R7: The leading-edge strobe fires for exactly one cycle at each k = P/2 + nP. The trailing-edge strobe fires for exactly one cycle at each k = nP, for n ≥ 1. Each strobe fires in the first cycle of the new `sclk_o` level.
- R8: With `edge_sel_i` = 0, `sample_stb_o` follows the leading edge and `shift_stb_o` follows the trailing edge; with `edge_sel_i` = 1 the two are swapped. The two strobes are never high together.
- R9: During reset, `sclk_o` equals `invert_i` and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Functional input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_en_i | input | 1 | Global enable; low holds counters cleared |
| pre_sel_i | input | 2 | First-stage ratio index |
| post_sel_i | input | 2 | Second-stage ratio code |
| invert_i | input | 1 | Idle level of the bit clock |
| edge_sel_i | input | 1 | Swaps the shift and sample edges |
| start_i | input | 1 | Restarts the period at the next cycle |
| sclk_o | output | 1 | Bit clock |
| shift_stb_o | output | 1 | One-cycle strobe for shifting data out |
| sample_stb_o | output | 1 | One-cycle strobe for sampling data in |

## Verification
The assertions check several properties on every cycle. Both counters stay inside their ratios. The stage-one tick and both strobes are single-cycle pulses. Each strobe coincides with a change of the internal phase in the matching direction. The two strobes are never high together. Disabling or starting returns the outputs to idle on the next cycle.

What the assertions cannot show is the actual ratio picked by each index and code, or the exact cycle of every edge. Those come only from the bench scenarios. The bench sweeps every ratio combination, including the odd first-stage ratio and the duplicate code. It also covers both polarities and both edge assignments, and it restarts in mid-period.

// File: rtl/sclk_prescale_pkg.sv
package sclk_prescale_pkg;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned PRE_R0  = 2;
  localparam int unsigned PRE_R1  = 4;
  localparam int unsigned PRE_R2  = 7;
  localparam int unsigned PRE_R3  = 10;
  localparam int unsigned PRE_MAX = PRE_R3;
  localparam int unsigned PRE_CW  = $clog2(PRE_MAX);
  localparam int unsigned POST_MAX = 8;
  localparam int unsigned POST_CW  = $clog2(POST_MAX);
  localparam int unsigned POST_RW  = POST_CW + 1;

  typedef enum logic [SEL_W-1:0] {
    POST_DIV2  = 2'b00,
    POST_DIV4  = 2'b01,
    POST_DIV8  = 2'b10,
    POST_DIV8B = 2'b11
  } post_code_e;

  function automatic logic [PRE_CW-1:0] pre_ratio(input logic [SEL_W-1:0] sel);
    case (sel)
      2'd0:    pre_ratio = PRE_CW'(PRE_R0);
      2'd1:    pre_ratio = PRE_CW'(PRE_R1);
      2'd2:    pre_ratio = PRE_CW'(PRE_R2);
      default: pre_ratio = PRE_CW'(PRE_R3);
    endcase
  endfunction

  function automatic logic [POST_RW-1:0] post_ratio(input post_code_e code);
    case (code)
      POST_DIV2: post_ratio = POST_RW'(2);
      POST_DIV4: post_ratio = POST_RW'(4);
      default:   post_ratio = POST_RW'(POST_MAX);
    endcase
  endfunction
endpackage

// File: rtl/sclk_pre_div.sv
module sclk_pre_div #(
  parameter int unsigned CW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic [CW-1:0] ratio_i,
  output logic          tick_o
);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap   = (cnt_q >= ratio_i - CW'(1));
  assign tick_o = !clear_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (wrap)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CW'(1);
  end

  // R1
  pre_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < ratio_i);
  // R1
  pre_tick_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/sclk_post_div.sv
module sclk_post_div #(
  parameter int unsigned CW = 3,
  localparam int unsigned RW = CW + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          tick_i,
  input  logic [RW-1:0] ratio_i,
  output logic          phase_o,
  output logic          lead_o,
  output logic          trail_o
);
  logic [CW-1:0] cnt_q;
  logic [RW-1:0] half;
  logic          lead_d, trail_d, ph_q, lead_q, trail_q;

  assign half    = ratio_i >> 1;
  assign lead_d  = tick_i && ({1'b0, cnt_q} == half - RW'(1));
  assign trail_d = tick_i && ({1'b0, cnt_q} == ratio_i - RW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ph_q    <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else if (clear_i) begin
      cnt_q   <= '0;
      ph_q    <= 1'b0;
      lead_q  <= 1'b0;
      trail_q <= 1'b0;
    end else begin
      lead_q  <= lead_d;
      trail_q <= trail_d;
      if (trail_d)     cnt_q <= '0;
      else if (tick_i) cnt_q <= cnt_q + CW'(1);
      if (lead_d)       ph_q <= 1'b1;
      else if (trail_d) ph_q <= 1'b0;
    end
  end

  assign phase_o = ph_q;
  assign lead_o  = lead_q;
  assign trail_o = trail_q;

  // R2
  post_cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, cnt_q} < ratio_i);
  // R7
  lead_on_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |-> ph_q && !$past(ph_q));
  // R7
  trail_on_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trail_q |-> !ph_q && $past(ph_q));
  // R7
  lead_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_q |=> !lead_q);
endmodule

// File: rtl/sclk_edge_map.sv
module sclk_edge_map (
  input  logic lead_i,
  input  logic trail_i,
  input  logic edge_sel_i,
  output logic shift_o,
  output logic sample_o
);
  always_comb begin
    if (edge_sel_i) begin
      shift_o  = lead_i;
      sample_o = trail_i;
    end else begin
      shift_o  = trail_i;
      sample_o = lead_i;
    end
  end
endmodule

// File: rtl/sclk_prescaler.sv
module sclk_prescaler
  import sclk_prescale_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clk_en_i,
  input  logic [SEL_W-1:0] pre_sel_i,
  input  logic [SEL_W-1:0] post_sel_i,
  input  logic             invert_i,
  input  logic             edge_sel_i,
  input  logic             start_i,
  output logic             sclk_o,
  output logic             shift_stb_o,
  output logic             sample_stb_o
);
  logic               clear, tick, phase, lead, trail;
  logic [PRE_CW-1:0]  pre_r;
  logic [POST_RW-1:0] post_r;

  assign clear  = !clk_en_i || start_i;
  assign pre_r  = pre_ratio(pre_sel_i);
  assign post_r = post_ratio(post_code_e'(post_sel_i));

  sclk_pre_div #(.CW(PRE_CW)) u_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .ratio_i (pre_r),
    .tick_o  (tick)
  );

  sclk_post_div #(.CW(POST_CW)) u_post (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .tick_i  (tick),
    .ratio_i (post_r),
    .phase_o (phase),
    .lead_o  (lead),
    .trail_o (trail)
  );

  sclk_edge_map u_map (
    .lead_i     (lead),
    .trail_i    (trail),
    .edge_sel_i (edge_sel_i),
    .shift_o    (shift_stb_o),
    .sample_o   (sample_stb_o)
  );

  assign sclk_o = phase ^ invert_i;

  // R8
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(shift_stb_o && sample_stb_o));
  // R4
  disable_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clk_en_i |=> (sclk_o == invert_i) && !shift_stb_o && !sample_stb_o);
  // R6
  start_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (sclk_o == invert_i) && !shift_stb_o && !sample_stb_o);
  // R7
  shift_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_stb_o |=> !shift_stb_o);
endmodule

// File: tb/sclk_prescaler_test.sv
module sclk_prescaler_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       en, inv, esel, start;
  logic [1:0] pre_sel, post_sel;
  logic       sclk, shift_stb, sample_stb;

  typedef struct { int k; bit is_sample; } ev_t;
  ev_t exp_q[$];

  int n_checks = 0;
  int n_fail   = 0;
  int mon_k    = 0;
  bit mon_on   = 0;
  bit cur_inv  = 0;
  bit cur_esel = 0;
  int cur_p    = 4;

  sclk_prescaler uut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .clk_en_i     (en),
    .pre_sel_i    (pre_sel),
    .post_sel_i   (post_sel),
    .invert_i     (inv),
    .edge_sel_i   (esel),
    .start_i      (start),
    .sclk_o       (sclk),
    .shift_stb_o  (shift_stb),
    .sample_stb_o (sample_stb)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic int pre_of(input int s);
    case (s) 0: return 2; 1: return 4; 2: return 7; default: return 10; endcase
  endfunction

  function automatic int post_of(input int c);
    case (c) 0: return 2; 1: return 4; default: return 8; endcase
  endfunction

  // Expected edges for cycles 1..n-1 of a fresh period (R3, R7, R8)
  task automatic fill(input int n);
    ev_t e;
    for (int k = 1; k < n; k++) begin
      if (k % cur_p == cur_p / 2) begin
        e.k = k; e.is_sample = !cur_esel; exp_q.push_back(e);
      end else if (k % cur_p == 0) begin
        e.k = k; e.is_sample = cur_esel; exp_q.push_back(e);
      end
    end
  endtask

  // Monitor / scoreboard
  always @(negedge clk) begin
    if (mon_on) begin
      int exp_lvl, exp_sh, exp_sa;
      ev_t e;
      exp_lvl = cur_inv ^ ((mon_k % cur_p) >= cur_p / 2);
      chk("R3 sclk level", sclk, exp_lvl);
      exp_sh = 0; exp_sa = 0;
      if (exp_q.size() > 0 && exp_q[0].k == mon_k) begin
        e = exp_q.pop_front();
        if (e.is_sample) exp_sa = 1; else exp_sh = 1;
      end
      chk("R7 shift strobe", shift_stb, exp_sh);
      chk("R8 sample strobe", sample_stb, exp_sa);
      mon_k++;
    end
  end

  task automatic drive_slot;
    @(posedge clk);
    #(CLK_PERIOD/4);
  endtask

  task automatic run(input int pre, input int post, input bit iv, input bit es,
                     input int ncyc, input int restart_at);
    drive_slot();
    pre_sel = pre[1:0]; post_sel = post[1:0]; inv = iv; esel = es;
    cur_p = pre_of(pre) * post_of(post); cur_inv = iv; cur_esel = es;
    exp_q.delete();
    if (restart_at > 0) begin
      fill(restart_at);
      mon_k = 0; mon_on = 1; en = 1'b1;
      repeat (restart_at) @(posedge clk);
      #(CLK_PERIOD/4);
      mon_on = 0;
      chk("R6 edges before restart", exp_q.size(), 0);
      exp_q.delete();
      start = 1'b1;
      drive_slot();
      start = 1'b0;
    end
    fill(ncyc);
    mon_k = 0; mon_on = 1; en = 1'b1;
    repeat (ncyc) @(posedge clk);
    #(CLK_PERIOD/4);
    mon_on = 0;
    chk("R3 missing edges", exp_q.size(), 0);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 idle level after disable", sclk, iv);
    chk("R4 no shift after disable", shift_stb, 0);
    chk("R4 no sample after disable", sample_stb, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_checks++; n_fail++;
    $display("FAIL R3: watchdog expired, actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; inv = 1'b0; esel = 1'b0; start = 1'b0;
    pre_sel = 2'd0; post_sel = 2'd0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R9 reset sclk", sclk, 0);
    chk("R9 reset shift", shift_stb, 0);
    chk("R9 reset sample", sample_stb, 0);
    inv = 1'b1;
    @(negedge clk);
    chk("R5 R9 reset idle high", sclk, 1);
    drive_slot();
    rst_n = 1'b1;
    inv = 1'b0;

    // R1 R2 sweep of every ratio pair, alternating polarity and edges
    for (int p = 0; p < 4; p++)
      for (int q = 0; q < 4; q++)
        run(p, q, bit'((p + q) % 2), bit'(q % 2),
            2 * pre_of(p) * post_of(q) + 1, 0);

    // R2 code 11 matches code 10 over a longer run
    run(3, 3, 1'b0, 1'b0, 3 * 80, 0);
    run(3, 2, 1'b1, 1'b1, 3 * 80, 0);

    // R6 restart in mid-period
    run(1, 0, 1'b0, 1'b0, 20, 5);
    run(0, 1, 1'b1, 1'b1, 20, 3);
    run(2, 1, 1'b0, 1'b1, 60, 17);

    // R4 held disabled with inversion: no strobe over many cycles
    drive_slot();
    inv = 1'b1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      chk("R4 R5 disabled idle", sclk, 1);
      chk("R4 disabled shift", shift_stb, 0);
      chk("R4 disabled sample", sample_stb, 0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule